// File: doc/BRIEF.md
# Writable Control Store Access Port

This block gives a processor's software a narrow door into its writable microcode store. The store holds a set of 1024-word banks of 32-bit microinstructions, three banks by default. Software first loads a 16-bit address word. That word picks a bank, says whether the writable store (rather than fixed ROM) is the target, picks which 16-bit half a read returns, and gives a 10-bit word address within the bank. A write then delivers both 16-bit halves together. A read returns the chosen half one cycle after its strobe.

The stored image carries a fixed polarity correction. Every word is XORed with a constant mask on the way in, and with the same mask on the way out. A location that was never written therefore reads back as the mask itself. A two-bit configuration input states how much writable store the machine has. On the ROM-only configurations the bank is always forced to zero. On the full writable configuration an out-of-range bank is pulled down to the last bank.

Top module: `ucram_port`

## Requirements
- R1: A pulse on `addr_load` captures `addr_word` into the address register, and the new address is used from the next cycle on. The fields are: bits 13:12 are the bank, bit 11 low selects the writable store, bit 10 low selects the low half, and bits 9:0 are the word address. Bits 15:14 are ignored.
- R2: At load time the bank is clipped by `cfg_mode`. With `cfg_mode` = 2 (full writable store), a bank above 2 becomes 2. With any other `cfg_mode` value (0 or 1 for the ROM-only machines, 3 reserved), the bank becomes 0.
- R3: A write (`wr_en`) stores the 32-bit word {`wr_hi`,`wr_lo`} at location bank*1024 + word address. Locations that differ only in bank are independent.
- R4: A write while the writable store is not selected changes no location.
- R5: Words are kept XORed with 32'h0008_8400 and XORed again on readback. A location never written since reset reads as 16'h8400 (low half) or 16'h0008 (high half).
- R6: A read returns bits 15:0 of the word when the low half is selected, and bits 31:16 otherwise.
- R7: `rd_valid` is high in exactly the cycle after each cycle with `rd_en` high, and `rd_data` carries the result in that cycle. `rd_data` is 0 whenever `rd_valid` is low.
- R8: A read in the cycle after a write to the same location returns the new word. A read in the same cycle as a write to that location returns the previous contents.
- R9: A read while the writable store is not selected returns 0 with `rd_err` high, for that one result cycle only. `rd_err` is never high without `rd_valid`.
- R10: After reset the outputs are 0, every location reads as never written, and the address register selects bank 0, the writable store, the low half and word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Machine store configuration: 0, 1 ROM-only, 2 full writable, 3 reserved |
| addr_load | input | 1 | Capture `addr_word` into the address register |
| addr_word | input | 16 | Packed bank, select bits and word address |
| wr_en | input | 1 | Write strobe |
| wr_lo | input | 16 | Low half of the write word |
| wr_hi | input | 16 | High half of the write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Selected half of the addressed word |
| rd_valid | output | 1 | Read result present this cycle |
| rd_err | output | 1 | Read was aimed at ROM; data forced to 0 |

## Verification
The bench builds the block with its default parameters: three 1024-word banks of 32 bits and a 16-bit address word. These are the only values for which the packed field positions in R1 hold, and with them the clamp from bank 3 down to bank 2 can be reached. Because the full three-bank depth is present, writes through a clamped bank and through a bank forced to zero can be read back through an explicitly named bank. This makes the effect of the configuration visible at the data port.

// File: rtl/ucram_pkg.sv
package ucram_pkg;

  typedef enum logic [1:0] {
    CFG_ROM_SMALL = 2'd0,
    CFG_ROM_LARGE = 2'd1,
    CFG_RAM_FULL  = 2'd2,
    CFG_RESERVED  = 2'd3
  } store_cfg_e;

  // fixed polarity correction applied to every stored word
  localparam logic [31:0] STORE_POLARITY = 32'h0008_8400;

endpackage

// File: rtl/ucram_addr_reg.sv
module ucram_addr_reg #(
  parameter int WORD_AW   = 10,
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 3,
  parameter int IN_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [IN_W-1:0]    word_in,
  input  logic [1:0]         cfg,
  output logic [BANK_W-1:0]  bank_q,
  output logic               ram_sel_q,
  output logic               lo_sel_q,
  output logic [WORD_AW-1:0] waddr_q
);
  import ucram_pkg::*;

  localparam int LO_BIT   = WORD_AW;
  localparam int RAM_BIT  = WORD_AW + 1;
  localparam int BANK_LSB = WORD_AW + 2;
  localparam int USED_W   = BANK_LSB + BANK_W;
  localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] raw_bank;
  logic [BANK_W-1:0] clip_bank;

  assign raw_bank = word_in[BANK_LSB +: BANK_W];

  always_comb begin
    if (store_cfg_e'(cfg) == CFG_RAM_FULL) begin
      clip_bank = (raw_bank > BANK_MAX) ? BANK_MAX : raw_bank;
    end else begin
      clip_bank = '0;
    end
  end

  generate
    if (IN_W > USED_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^word_in[IN_W-1:USED_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q    <= '0;
      ram_sel_q <= 1'b1;
      lo_sel_q  <= 1'b1;
      waddr_q   <= '0;
    end else if (load) begin
      bank_q    <= clip_bank;
      ram_sel_q <= ~word_in[RAM_BIT];
      lo_sel_q  <= ~word_in[LO_BIT];
      waddr_q   <= word_in[WORD_AW-1:0];
    end
  end

endmodule

// File: rtl/ucram_store.sv
module ucram_store #(
  parameter int DEPTH  = 3072,
  parameter int IDX_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rwritten_q
);

  // array body: no reset, so it maps onto block RAM
  logic [DATA_W-1:0] mem [DEPTH];
  // per-location "written since reset" flags; unwritten words read as zero
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
    if (re) begin
      rdata_q <= mem[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written    <= '0;
      rwritten_q <= 1'b0;
    end else begin
      if (we) begin
        written[widx] <= 1'b1;
      end
      if (re) begin
        rwritten_q <= written[ridx];
      end
    end
  end

endmodule

// File: rtl/ucram_rd_stage.sv
module ucram_rd_stage #(
  parameter int HALF_W = 16,
  parameter int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic              ram_sel,
  input  logic              lo_sel,
  input  logic [DATA_W-1:0] raw_q,
  input  logic              written_q,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  import ucram_pkg::*;

  localparam logic [DATA_W-1:0] POL = DATA_W'(STORE_POLARITY);

  logic              valid_q;
  logic              err_q;
  logic              lo_q;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] logical;
  logic [HALF_W-1:0] half;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      lo_q    <= 1'b1;
    end else begin
      valid_q <= re;
      err_q   <= re & ~ram_sel;
      if (re) begin
        lo_q <= lo_sel;
      end
    end
  end

  always_comb begin
    stored  = written_q ? raw_q : '0;
    logical = stored ^ POL;
    half    = lo_q ? logical[HALF_W-1:0] : logical[DATA_W-1:HALF_W];
  end

  assign rd_data  = (valid_q && !err_q) ? half : '0;
  assign rd_valid = valid_q;
  assign rd_err   = err_q;

endmodule

// File: rtl/ucram_port.sv
module ucram_port #(
  parameter int WORD_AW   = 10,
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 3,
  parameter int HALF_W    = 16,
  parameter int ADDR_IN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              addr_load,
  input  logic [ADDR_IN_W-1:0] addr_word,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_lo,
  input  logic [HALF_W-1:0] wr_hi,
  input  logic              rd_en,
  output logic [HALF_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_err
);
  import ucram_pkg::*;

  localparam int WORDS  = 1 << WORD_AW;
  localparam int DEPTH  = NUM_BANKS * WORDS;
  localparam int IDX_W  = BANK_W + WORD_AW;
  localparam int DATA_W = 2 * HALF_W;
  localparam logic [DATA_W-1:0] POL = DATA_W'(STORE_POLARITY);

  logic [BANK_W-1:0]  bank_q;
  logic               ram_sel_q;
  logic               lo_sel_q;
  logic [WORD_AW-1:0] waddr_q;
  logic [IDX_W-1:0]   loc_idx;
  logic               mem_we;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  raw_q;
  logic               written_q;

  ucram_addr_reg #(
    .WORD_AW  (WORD_AW),
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS),
    .IN_W     (ADDR_IN_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (addr_load),
    .word_in  (addr_word),
    .cfg      (cfg_mode),
    .bank_q   (bank_q),
    .ram_sel_q(ram_sel_q),
    .lo_sel_q (lo_sel_q),
    .waddr_q  (waddr_q)
  );

  // bank * WORDS + address, with WORDS a power of two
  assign loc_idx   = {bank_q, waddr_q};
  assign mem_we    = wr_en & ram_sel_q;
  assign mem_wdata = {wr_hi, wr_lo} ^ POL;

  ucram_store #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .we        (mem_we),
    .widx      (loc_idx),
    .wdata     (mem_wdata),
    .re        (rd_en),
    .ridx      (loc_idx),
    .rdata_q   (raw_q),
    .rwritten_q(written_q)
  );

  ucram_rd_stage #(
    .HALF_W(HALF_W),
    .DATA_W(DATA_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .re       (rd_en),
    .ram_sel  (ram_sel_q),
    .lo_sel   (lo_sel_q),
    .raw_q    (raw_q),
    .written_q(written_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_err   (rd_err)
  );

endmodule

// File: rtl/ucram_port_chk.sv
module ucram_port_chk #(
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 3,
  parameter int HALF_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic              addr_load,
  input logic              rd_en,
  input logic [HALF_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_err,
  input logic [BANK_W-1:0] bank_q,
  input logic              ram_sel_q
);
  localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !addr_load |=> ($stable(bank_q) && $stable(ram_sel_q))); // R1

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
    bank_q <= BANK_MAX); // R2

  AST_ROM_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr_load && cfg_mode != 2'd2) |=> (bank_q == '0)); // R2

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R7

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && rd_data == '0)); // R7

  AST_ROM_READ_ERR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ram_sel_q) |=> (rd_err && rd_data == '0)); // R9

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> rd_valid); // R9

endmodule

bind ucram_port ucram_port_chk #(
  .BANK_W   (BANK_W),
  .NUM_BANKS(NUM_BANKS),
  .HALF_W   (HALF_W)
) u_chk (.*);

// File: tb/ucram_port_test.sv
module ucram_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POL = 32'h0008_8400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd2;
  logic        addr_load = 1'b0;
  logic [15:0] addr_word = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_lo = '0;
  logic [15:0] wr_hi = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        rd_err;

  int n_checks = 0;
  int n_bad = 0;

  // bench-side model of the logical store and the address register
  logic [31:0] model [int];
  int cur_bank = 0;
  bit cur_ram = 1'b1;
  bit cur_lo = 1'b1;
  int cur_addr = 0;

  // scoreboard queues
  logic [15:0] exp_data_q [$];
  bit          exp_err_q  [$];
  string       exp_tag_q  [$];

  ucram_port uut (
    .clk      (clk),
    .rst      (rst),
    .cfg_mode (cfg_mode),
    .addr_load(addr_load),
    .addr_word(addr_word),
    .wr_en    (wr_en),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_err   (rd_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (exp_data_q.size() == 0) begin
          n_checks++;
          n_bad++;
          $display("FAIL R7 unexpected result: actual=%h expected=none", rd_data);
        end else begin
          string t;
          logic [15:0] ed;
          bit ee;
          t  = exp_tag_q.pop_front();
          ed = exp_data_q.pop_front();
          ee = exp_err_q.pop_front();
          check({t, " data"}, {16'h0, rd_data}, {16'h0, ed});
          check({t, " err"}, {31'h0, rd_err}, {31'h0, ee});
        end
      end else if (rd_err) begin
        n_checks++;
        n_bad++;
        $display("FAIL R9 err without valid: actual=1 expected=0");
      end
    end
  end

  function automatic void expected(output logic [15:0] d, output bit e);
    logic [31:0] w;
    int key;
    key = cur_bank * 1024 + cur_addr;
    if (!cur_ram) begin
      d = 16'h0;
      e = 1'b1;
    end else begin
      w = model.exists(key) ? model[key] : POL;
      d = cur_lo ? w[15:0] : w[31:16];
      e = 1'b0;
    end
  endfunction

  task automatic load(int b, bit ram_n, bit lo_n, int a);
    addr_word = {2'b00, 2'(b), ram_n, lo_n, 10'(a)};
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
    cur_bank = (cfg_mode == 2'd2) ? ((b > 2) ? 2 : b) : 0;
    cur_ram  = !ram_n;
    cur_lo   = !lo_n;
    cur_addr = a;
  endtask

  task automatic wr(logic [15:0] hi, logic [15:0] lo);
    wr_hi = hi;
    wr_lo = lo;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (cur_ram) model[cur_bank * 1024 + cur_addr] = {hi, lo};
  endtask

  task automatic rd(string tag);
    logic [15:0] d;
    bit e;
    expected(d, e);
    exp_data_q.push_back(d);
    exp_err_q.push_back(e);
    exp_tag_q.push_back(tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // write and read in one cycle: the read sees the old word
  task automatic rd_wr(logic [15:0] hi, logic [15:0] lo, string tag);
    logic [15:0] d;
    bit e;
    expected(d, e);
    exp_data_q.push_back(d);
    exp_err_q.push_back(e);
    exp_tag_q.push_back(tag);
    wr_hi = hi;
    wr_lo = lo;
    wr_en = 1'b1;
    rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (cur_ram) model[cur_bank * 1024 + cur_addr] = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state of the outputs
    check("R10 rd_data after reset", {16'h0, rd_data}, 32'h0);
    check("R10 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
    check("R10 rd_err after reset", {31'h0, rd_err}, 32'h0);

    // R10/R5 reset address: bank 0, writable, low half, word 0, unwritten
    rd("R10 R5 unwritten low half after reset");
    load(0, 1'b0, 1'b1, 0);
    rd("R5 unwritten high half");

    // R3 R6 R8: write then read in the next cycle, both halves
    load(1, 1'b0, 1'b0, 5);
    wr(16'h1234, 16'hABCD);
    rd("R8 R3 read right after write, low");
    load(1, 1'b0, 1'b1, 5);
    rd("R6 high half");
    rd("R7 back-to-back read");
    load(0, 1'b0, 1'b0, 5);
    rd("R3 other bank untouched");
    load(2, 1'b0, 1'b1, 1023);
    wr(16'hFFFF, 16'h0000);
    rd("R3 last word of bank 2");

    // R4 R9: write and read aimed at ROM
    load(0, 1'b1, 1'b0, 7);
    wr(16'hFFFF, 16'hFFFF);
    rd("R9 ROM read gives zero and error");
    load(0, 1'b0, 1'b0, 7);
    rd("R4 ROM-directed write ignored");
    check("R9 error lasts one cycle", {31'h0, rd_err}, 32'h0);

    // R2 clipping by configuration
    cfg_mode = 2'd2;
    load(3, 1'b0, 1'b0, 9);
    wr(16'h5555, 16'hAAAA);
    load(2, 1'b0, 1'b0, 9);
    rd("R2 bank 3 clamped to 2");
    cfg_mode = 2'd0;
    load(2, 1'b0, 1'b0, 9);
    wr(16'h1111, 16'h2222);
    cfg_mode = 2'd2;
    load(0, 1'b0, 1'b0, 9);
    rd("R2 small ROM config forces bank 0");
    load(2, 1'b0, 1'b0, 9);
    rd("R2 bank 2 unchanged by bank 0 write");
    cfg_mode = 2'd1;
    load(1, 1'b0, 1'b1, 9);
    rd("R2 large ROM config forces bank 0");
    cfg_mode = 2'd3;
    load(2, 1'b0, 1'b1, 9);
    rd("R2 reserved config forces bank 0");

    // R8 same-cycle collision
    cfg_mode = 2'd2;
    load(2, 1'b0, 1'b0, 20);
    rd_wr(16'h7777, 16'h8888, "R8 same-cycle read sees old word");
    rd("R8 following read sees new word");

    // R1 spare upper bits ignored
    addr_word = 16'hC000 | {2'b00, 2'd1, 1'b0, 1'b1, 10'd5};
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
    cur_bank = 1; cur_ram = 1'b1; cur_lo = 1'b0; cur_addr = 5;
    rd("R1 upper bits ignored");

    repeat (3) @(negedge clk);
    check("R7 all results arrived", exp_data_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule